// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a byte-programmed watchdog. Software writes one control byte that holds a
5-bit multiplier, a 2-bit resolution code and a steering bit. From these the block works out
a timeout in sixteenths of a second and counts it down on a 16 Hz enable supplied by a
prescaler elsewhere in the chip. When the count runs out, a sticky expiry flag is set. The
steering bit then selects the action: either a single interrupt pulse, or a system reset
request that also wipes the control byte and a century bit kept next to the watchdog.

Software keeps the watchdog alive by touching the control register. A write or a read
reloads the count, and so does a rewrite of the same value. A control value whose timeout
works out to zero leaves the watchdog idle.

Requests arrive on a valid/ready register port. The block holds `bus_ready` low only while
a read response is waiting and `rsp_ready` is low. A read returns its byte on a
valid/ready response channel one cycle after acceptance. The response stays stable until it
is taken. A write produces no response.

Top module: `wdog_steer`

## Requirements
- R1: The control byte at address 0x1FF7 decodes as resolution = bits 1:0, multiplier = bits 6:2, steering = bit 7. The timeout is multiplier × 4^resolution ticks of `tick16`, so values range from 1 to 31 × 64 = 1984.
- R2: When the decoded timeout is zero (multiplier 0), no number of ticks causes an expiry.
- R3: A write to 0x1FF7 stores the byte, clears the expiry flag and restarts the countdown from the new timeout.
- R4: A read of 0x1FF7 returns the stored byte, clears the expiry flag and restarts the countdown from the stored timeout, as a rewrite of the same value would.
- R5: The tick that brings the count to zero sets bit 7 of `flags_o` (other bits read 0). The flag, the pulse and the cleared registers all become visible in the cycle after the clock edge that samples that tick.
- R6: With steering = 1 at expiry, `rst_req` pulses high for exactly one cycle, `irq_pulse` stays low, and the control byte and the century bit (bit 6 of 0x1FFC) both read back as 0x00.
- R7: With steering = 0 at expiry, `irq_pulse` pulses high for exactly one cycle and `rst_req` stays low. The count then stays stopped, and further ticks produce no pulse until the next access to 0x1FF7.
- R8: The flags register at 0x1FF0 is read-only. Writes to it leave `flags_o` unchanged, and a read returns the value on `flags_o`.
- R9: If an access to 0x1FF7 and the expiring tick fall in the same cycle, the access wins. No flag and no pulse are produced, and the count restarts.
- R10: A read is accepted on `bus_valid && bus_ready`, and its response appears with `rsp_valid` in the next cycle. While `rsp_valid && !rsp_ready`, `rsp_data` and `rsp_valid` hold and `bus_ready` is low.
- R11: A write to 0x1FF8+4 = 0x1FFC keeps only bit 6 (the century bit). A read of 0x1FFC returns that bit in position 6 with all other bits 0.
- R12: A read of any other address returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request can be accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data |
| tick16 | input | 1 | One-cycle 16 Hz enable |
| irq_pulse | output | 1 | One-cycle interrupt on non-reset expiry |
| rst_req | output | 1 | One-cycle reset request on steered expiry |
| flags_o | output | 8 | Flags register, bit 7 = expiry flag |

## Verification
A countdown that was loaded with the wrong value shows up as an expiry one or more ticks
early or late. The bench therefore counts ticks and checks that the tick just before the
timeout leaves `flags_o` clear and that the final tick raises it in the following cycle. A
counter that failed to stop or failed to reload shows up as an extra pulse, or as a missing
pulse, within a single tick after an expiry or an access. Wrong steering state shows up in
the same cycle as the expiry: the wrong pulse fires, or the control and century bytes are
not cleared when read back right afterwards.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int NRES   = 1 << RES_W;
  localparam int CNT_W  = MULT_W + 2 * (NRES - 1);

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdog_ctrl_t;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_CTRL = 2'd1,
    HIT_FLAG = 2'd2,
    HIT_CENT = 2'd3
  } hit_e;
endpackage

// File: rtl/wdog_bus.sv
module wdog_bus
  import wdog_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter logic [12:0] CTRL_ADDR = 13'h1FF7,
  parameter logic [12:0] FLAG_ADDR = 13'h1FF0,
  parameter logic [12:0] CENT_ADDR = 13'h1FFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  input  logic [7:0]        rd_value,
  output logic              fire,
  output hit_e              hit
);
  logic       rv_q;
  logic [7:0] rd_q;

  assign bus_ready = !rv_q || rsp_ready;
  assign fire      = bus_valid && bus_ready;

  always_comb begin
    hit = HIT_NONE;
    if (bus_addr == ADDR_W'(CTRL_ADDR))      hit = HIT_CTRL;
    else if (bus_addr == ADDR_W'(FLAG_ADDR)) hit = HIT_FLAG;
    else if (bus_addr == ADDR_W'(CENT_ADDR)) hit = HIT_CENT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= 8'h00;
    end else if (fire && !bus_write) begin
      rv_q <= 1'b1;
      rd_q <= rd_value;
    end else if (rsp_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !rsp_ready) |=> (rv_q && $stable(rd_q)));

  // R10
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !rsp_ready) |-> !bus_ready);
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval
  import wdog_pkg::*;
(
  input  wdog_ctrl_t       ctrl,
  output logic [CNT_W-1:0] reload
);
  logic [CNT_W-1:0] cand [NRES];

  for (genvar k = 0; k < NRES; k++) begin : g_scale
    assign cand[k] = CNT_W'(ctrl.mult) << (2 * k);
  end

  assign reload = cand[ctrl.res];
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  assign expire = act_q && tick && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      cnt_q <= reload;
      act_q <= (reload != '0);
    end else if (act_q && tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) act_q <= 1'b0;
    end
  end

  // R7
  stop_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !act_q);

  // R2
  active_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q != '0));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !expire);
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  input  logic              tick16,
  output logic              irq_pulse,
  output logic              rst_req,
  output logic [7:0]        flags_o
);
  wdog_ctrl_t       ctrl_q;
  wdog_ctrl_t       src;
  logic             flag_q;
  logic             cent_q;
  logic             irq_q;
  logic             rst_q;
  logic             fire;
  hit_e             hit;
  logic [7:0]       rd_value;
  logic             ctrl_acc;
  logic [CNT_W-1:0] reload;
  logic             expire;

  wdog_bus #(.ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rd_value  (rd_value),
    .fire      (fire),
    .hit       (hit)
  );

  assign ctrl_acc = fire && (hit == HIT_CTRL);
  assign src      = (ctrl_acc && bus_write) ? wdog_ctrl_t'(bus_wdata) : ctrl_q;

  wdog_interval u_int (
    .ctrl   (src),
    .reload (reload)
  );

  wdog_count u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ctrl_acc),
    .reload (reload),
    .tick   (tick16),
    .expire (expire)
  );

  always_comb begin
    case (hit)
      HIT_CTRL: rd_value = ctrl_q;
      HIT_FLAG: rd_value = flags_o;
      HIT_CENT: rd_value = {1'b0, cent_q, 6'b0};
      default:  rd_value = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      cent_q <= 1'b0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      irq_q <= expire && !ctrl_q.steer;
      rst_q <= expire && ctrl_q.steer;
      if (fire && bus_write && hit == HIT_CENT) cent_q <= bus_wdata[6];
      if (ctrl_acc) begin
        flag_q <= 1'b0;
        if (bus_write) ctrl_q <= wdog_ctrl_t'(bus_wdata);
      end else if (expire) begin
        flag_q <= 1'b1;
        if (ctrl_q.steer) begin
          ctrl_q <= '0;
          cent_q <= 1'b0;
        end
      end
    end
  end

  assign irq_pulse = irq_q;
  assign rst_req   = rst_q;
  assign flags_o   = {flag_q, 7'b0};

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_q && rst_q));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R6
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (ctrl_q == '0 && !cent_q && flag_q));

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (irq_q || rst_q));
endmodule

// File: tb/sim_wdog_steer.sv
`timescale 1ns/1ps
module sim_wdog_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        tick16 = 1'b0;
  logic        irq_pulse;
  logic        rst_req;
  logic [7:0]  flags_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wdog_steer u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .tick16(tick16), .irq_pulse(irq_pulse), .rst_req(rst_req), .flags_o(flags_o)
  );

  localparam logic [12:0] A_CTRL = 13'h1FF7;
  localparam logic [12:0] A_FLAG = 13'h1FF0;
  localparam logic [12:0] A_CENT = 13'h1FFC;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick16 = 1'b1;
      @(negedge clk); tick16 = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R5 reset flags", flags_o, 8'h00);
    chk("R7 reset irq", {7'b0, irq_pulse}, 8'h00);
    chk("R6 reset rst_req", {7'b0, rst_req}, 8'h00);
    rd(A_CTRL, d);
    chk("R4 reset ctrl read", d, 8'h00);
  endtask

  task automatic t_irq_expiry();
    logic [7:0] d;
    wr(A_CTRL, 8'h05);            // mult 1, res 1 -> 4 ticks
    ticks(3);
    chk("R1 no flag before 4th tick", flags_o, 8'h00);
    ticks(1);
    chk("R5 flag after 4th tick", flags_o, 8'h80);
    chk("R7 irq pulse", {7'b0, irq_pulse}, 8'h01);
    chk("R7 no rst_req", {7'b0, rst_req}, 8'h00);
    @(negedge clk);
    chk("R7 irq single cycle", {7'b0, irq_pulse}, 8'h00);
    ticks(6);
    chk("R7 stopped, no repeat", {7'b0, irq_pulse}, 8'h00);
    wr(A_FLAG, 8'h00);
    chk("R8 flag write ignored", flags_o, 8'h80);
    rd(A_FLAG, d);
    chk("R8 flag read", d, 8'h80);
    rd(A_CTRL, d);
    chk("R4 ctrl readback", d, 8'h05);
    chk("R4 read clears flag", flags_o, 8'h00);
    wr(A_FLAG, 8'hFF);
    chk("R8 flag write ignored when clear", flags_o, 8'h00);
  endtask

  task automatic t_read_restart();
    logic [7:0] d;
    wr(A_CTRL, 8'h08);            // mult 2, res 0 -> 2 ticks
    ticks(1);
    rd(A_CTRL, d);                // restart to 2
    ticks(1);
    chk("R4 read restarted count", flags_o, 8'h00);
    ticks(1);
    chk("R4 expiry after restart", {7'b0, irq_pulse}, 8'h01);
    ticks(1);
    wr(A_CTRL, 8'h0C);            // mult 3 -> 3 ticks, clears flag
    chk("R3 write clears flag", flags_o, 8'h00);
    ticks(2);
    chk("R3 restart from new value", flags_o, 8'h00);
    ticks(1);
    chk("R3 expiry at new timeout", flags_o, 8'h80);
  endtask

  task automatic t_steer_reset();
    logic [7:0] d;
    wr(A_CENT, 8'hFF);
    rd(A_CENT, d);
    chk("R11 century keeps bit 6", d, 8'h40);
    wr(A_CTRL, 8'h84);            // steer, mult 1, res 0 -> 1 tick
    ticks(1);
    chk("R6 rst_req pulse", {7'b0, rst_req}, 8'h01);
    chk("R6 no irq", {7'b0, irq_pulse}, 8'h00);
    chk("R5 flag on reset expiry", flags_o, 8'h80);
    @(negedge clk);
    chk("R6 rst_req single cycle", {7'b0, rst_req}, 8'h00);
    rd(A_CENT, d);
    chk("R6 century cleared", d, 8'h00);
    rd(A_CTRL, d);
    chk("R6 ctrl cleared", d, 8'h00);
  endtask

  task automatic t_disabled();
    wr(A_CTRL, 8'h03);            // mult 0, res 3 -> zero
    ticks(20);
    chk("R2 zero timeout never fires", flags_o, 8'h00);
    chk("R2 no irq", {7'b0, irq_pulse}, 8'h00);
  endtask

  task automatic t_collision();
    wr(A_CTRL, 8'h04);            // 1 tick
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = A_CTRL; tick16 = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; tick16 = 1'b0;
    chk("R9 access beats expiry flag", flags_o, 8'h00);
    chk("R9 access beats expiry irq", {7'b0, irq_pulse}, 8'h00);
    ticks(1);
    chk("R9 restarted count fires", {7'b0, irq_pulse}, 8'h01);
  endtask

  task automatic t_max();
    wr(A_CTRL, 8'h7F);            // 31 * 64 = 1984 ticks
    ticks(1983);
    chk("R1 max, tick 1983 silent", flags_o, 8'h00);
    ticks(1);
    chk("R1 max, tick 1984 fires", {7'b0, irq_pulse}, 8'h01);
  endtask

  task automatic t_backpressure();
    logic [7:0] d;
    rsp_ready = 1'b0;
    rd(A_FLAG, d);
    chk("R10 response valid", {7'b0, rsp_valid}, 8'h01);
    chk("R10 response data", d, 8'h80);
    @(negedge clk);
    chk("R10 held valid", {7'b0, rsp_valid}, 8'h01);
    chk("R10 held data", rsp_data, 8'h80);
    chk("R10 ready low", {7'b0, bus_ready}, 8'h00);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 consumed", {7'b0, rsp_valid}, 8'h00);
    rd(13'h0123, d);
    chk("R12 unmapped read", d, 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_irq_expiry();
    t_read_restart();
    t_steer_reset();
    t_disabled();
    t_collision();
    t_max();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule